// File: doc/BRIEF.md
# Filtered Pass-Window Edge Locator

This block searches a 256-entry pass/fail map for the edges of a passing window, as seen when a delay setting is swept and each step is marked good (1) or bad (0). A request selects the kind of edge and the index at which to begin. The block then walks the map upward and returns the lowest index that carries that edge, or reports that none exists. Every edge must be backed by a short run of agreeing bits, so a lone passing or failing bit does not count as an edge.

A caller normally asks for a rising edge from the bottom of the map. It then asks for a falling edge, starting at the index the first search returned. The gap between the two results is the usable window. The map is copied into the block when a request is accepted, so the source may change while the search runs.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while a scan is in progress, and a request held during that time waits; nothing is queued. The result side has no back-pressure: `done` is a one-cycle pulse, and `found` and `found_idx` keep their values until the next `done`.

Top module: `pass_window_locator`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, `found` is 0 and `found_idx` is all ones (-1).
- R2: With `req_fall` = 0 (rising search), index i matches when map bit i-1 is 0 and bits i, i+1, i+2 and i+3 are all 1.
- R3: With `req_fall` = 1 (falling search), index i matches when map bit i is 0 and bits i-3, i-2 and i-1 are all 1.
- R4: The result is the lowest matching index that is at or above the effective start index. The search ends at the first match.
- R5: The effective start is the requested start, raised to 3 when it is below 3. For a rising search this includes a negative start (bit 8 of `req_start` set, two's complement). No index below 3 is ever reported.
- R6: No index above 252 is ever examined or reported. A start index from 253 to 255 ends the search at once with a not-found result.
- R7: A falling search with a negative start index ends at once with a not-found result, without scanning.
- R8: A not-found result gives `found` = 0 and `found_idx` = all ones (-1). A match gives `found` = 1 and `found_idx` = the index, zero-extended to 9 bits.
- R9: Let N be the number of indices examined: m-s+1 for a match at m from effective start s, 253-s when nothing matches, and 0 for an immediate end. `done` is high for exactly one cycle, in the cycle that follows the N-th clock edge after the accepting edge. With one index per clock, N is at most 250.
- R10: `req_ready` is low from the accepting edge until `done`, unless the request ends at once. Requests presented while it is low are not taken, and changes to `bitmap` after acceptance do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_fall | input | 1 | 0 = rising-edge search, 1 = falling-edge search |
| req_start | input | 9 | Signed start index (two's complement, -1 = none) |
| bitmap | input | 256 | Pass (1) / fail (0) map, bit i for step i |
| done | output | 1 | One-cycle result strobe |
| found | output | 1 | Last result was a match |
| found_idx | output | 9 | Last matching index, or all ones when not found |

## Verification
The hardest cases to reach from the ports are the near misses. One is a passing run one bit too short to count as an edge. Another is a failing bit inside a window, which a falling search does accept. A third is a window that ends so close to index 255 that its edge lies past the last examined index. The stimulus builds such maps on purpose: short runs, single flipped bits, and windows whose low edge is swept over the first few and the last few indices. It also uses maps made of random runs. Each rising result is fed back as the start of a falling search, so a not-found result also exercises the negative-start path. On long scans the bench presents a competing request while the block is busy, and at the same time inverts the bitmap input. The result must still reflect the map that was captured when the request was accepted.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_SCAN = 1'b1
  } scan_phase_e;
endpackage

// File: rtl/pwe_lane_match.sv
// Pattern test for one candidate index; win is centred on the candidate.
module pwe_lane_match #(
  parameter int RUN_LEN = 3
) (
  input  logic               fall_mode,
  input  logic               in_range,
  input  logic [2*RUN_LEN:0] win,
  output logic               hit
);
  logic rise_ok;
  logic fall_ok;

  always_comb begin
    rise_ok = !win[RUN_LEN-1] && (&win[2*RUN_LEN:RUN_LEN]);
    fall_ok = !win[RUN_LEN] && (&win[RUN_LEN-1:0]);
    hit     = in_range && (fall_mode ? fall_ok : rise_ok);
  end
endmodule

// File: rtl/pwe_first_hit.sv
// Lowest-lane priority pick among the candidates examined in one cycle.
module pwe_first_hit #(
  parameter int LANES  = 1,
  parameter int LANE_W = 1
) (
  input  logic [LANES-1:0]  hits,
  output logic              any_hit,
  output logic [LANE_W-1:0] lane
);
  always_comb begin
    any_hit = |hits;
    lane    = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (hits[l]) lane = LANE_W'(l);
    end
  end
endmodule

// File: rtl/pwe_scan_ctrl.sv
module pwe_scan_ctrl
  import pwe_pkg::*;
#(
  parameter int MAP_W   = 256,
  parameter int RUN_LEN = 3,
  parameter int LANES   = 1,
  parameter int CUR_W   = 8,
  parameter int LANE_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic              req_fall,
  input  logic [CUR_W:0]    req_start,
  input  logic              hit_any,
  input  logic [LANE_W-1:0] hit_lane,
  output logic              busy,
  output logic [CUR_W-1:0]  cursor,
  output logic              fall_q,
  output logic              done,
  output logic              found,
  output logic [CUR_W:0]    found_idx
);
  localparam int IDX_W = CUR_W + 1;
  localparam logic [CUR_W-1:0] FIRST_IDX = CUR_W'(RUN_LEN);
  localparam logic [CUR_W-1:0] LAST_IDX  = CUR_W'(MAP_W - 1 - RUN_LEN);
  localparam logic [CUR_W:0]   STEP      = (CUR_W + 1)'(LANES);

  scan_phase_e       phase_q;
  logic [CUR_W-1:0]  cur_q;
  logic              fall_r;
  logic              done_q;
  logic              found_q;
  logic [IDX_W-1:0]  idx_q;

  logic              start_neg;
  logic [CUR_W-1:0]  start_mag;
  logic              start_dead;
  logic [CUR_W-1:0]  start_pos;
  logic              last_step;
  logic [CUR_W-1:0]  hit_idx;

  always_comb begin
    start_neg  = req_start[IDX_W-1];
    start_mag  = req_start[CUR_W-1:0];
    start_dead = (start_neg && req_fall) || (!start_neg && (start_mag > LAST_IDX));
    start_pos  = (start_neg || (start_mag < FIRST_IDX)) ? FIRST_IDX : start_mag;
    last_step  = ({1'b0, cur_q} + STEP) > {1'b0, LAST_IDX};
    hit_idx    = cur_q + CUR_W'(hit_lane);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cur_q   <= FIRST_IDX;
      fall_r  <= 1'b0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      idx_q   <= '1;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (req_fire) begin
            if (start_dead) begin
              done_q  <= 1'b1;
              found_q <= 1'b0;
              idx_q   <= '1;
            end else begin
              phase_q <= PH_SCAN;
              cur_q   <= start_pos;
              fall_r  <= req_fall;
            end
          end
        end
        PH_SCAN: begin
          if (hit_any) begin
            done_q  <= 1'b1;
            found_q <= 1'b1;
            idx_q   <= {1'b0, hit_idx};
            phase_q <= PH_IDLE;
          end else if (last_step) begin
            done_q  <= 1'b1;
            found_q <= 1'b0;
            idx_q   <= '1;
            phase_q <= PH_IDLE;
          end else begin
            cur_q <= cur_q + STEP[CUR_W-1:0];
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (phase_q == PH_SCAN);
  assign cursor    = cur_q;
  assign fall_q    = fall_r;
  assign done      = done_q;
  assign found     = found_q;
  assign found_idx = idx_q;

  // R6
  cursor_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SCAN) |-> (cur_q >= FIRST_IDX) && (cur_q <= LAST_IDX));

  // R7
  fall_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_fall && req_start[IDX_W-1]) |=> (done_q && !found_q));

  // R8
  miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !found_q) |-> (idx_q == '1));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> ((phase_q == PH_SCAN) ^ done_q));

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(req_fire) || $past(phase_q == PH_SCAN)));
endmodule

// File: rtl/pass_window_locator.sv
module pass_window_locator #(
  parameter int MAP_W   = 256,
  parameter int RUN_LEN = 3,
  parameter int LANES   = 1,
  localparam int CUR_W  = $clog2(MAP_W),
  localparam int IDX_W  = CUR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_fall,
  input  logic [IDX_W-1:0] req_start,
  input  logic [MAP_W-1:0] bitmap,
  output logic             done,
  output logic             found,
  output logic [IDX_W-1:0] found_idx
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int WIN_W  = 2 * RUN_LEN + 1;
  localparam int SPAN_W = LANES + 2 * RUN_LEN;
  localparam int EXT_W  = MAP_W + LANES;
  localparam logic [CUR_W-1:0] LAST_IDX = CUR_W'(MAP_W - 1 - RUN_LEN);

  logic              fire;
  logic              busy;
  logic [CUR_W-1:0]  cursor;
  logic              fall_q;
  logic [MAP_W-1:0]  map_q;
  logic [EXT_W-1:0]  ext_map;
  logic [CUR_W-1:0]  base;
  logic [SPAN_W-1:0] span;
  logic [LANES-1:0]  lane_hits;
  logic              hit_any;
  logic [LANE_W-1:0] hit_lane;
  logic [CUR_W-1:0]  rep_at;

  assign req_ready = !busy;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) map_q <= '0;
    else if (fire) map_q <= bitmap;
  end

  // Zero pad above the map so out-of-range lanes read defined bits.
  assign ext_map = {{LANES{1'b0}}, map_q};
  assign base    = cursor - CUR_W'(RUN_LEN);
  assign span    = ext_map[base +: SPAN_W];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic in_rng;
    assign in_rng = ({1'b0, cursor} + (CUR_W + 1)'(l)) <= {1'b0, LAST_IDX};
    pwe_lane_match #(.RUN_LEN(RUN_LEN)) u_match (
      .fall_mode (fall_q),
      .in_range  (in_rng),
      .win       (span[l +: WIN_W]),
      .hit       (lane_hits[l])
    );
  end

  pwe_first_hit #(.LANES(LANES), .LANE_W(LANE_W)) u_pick (
    .hits    (lane_hits),
    .any_hit (hit_any),
    .lane    (hit_lane)
  );

  pwe_scan_ctrl #(
    .MAP_W(MAP_W), .RUN_LEN(RUN_LEN), .LANES(LANES),
    .CUR_W(CUR_W), .LANE_W(LANE_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (fire),
    .req_fall  (req_fall),
    .req_start (req_start),
    .hit_any   (hit_any),
    .hit_lane  (hit_lane),
    .busy      (busy),
    .cursor    (cursor),
    .fall_q    (fall_q),
    .done      (done),
    .found     (found),
    .found_idx (found_idx)
  );

  assign rep_at = found_idx[CUR_W-1:0];

  // R2
  rise_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found && !fall_q) |->
      (!map_q[rep_at - 1'b1] && (&ext_map[rep_at +: RUN_LEN + 1])));

  // R3
  fall_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found && fall_q) |->
      (!map_q[rep_at] && (&map_q[rep_at - CUR_W'(RUN_LEN) +: RUN_LEN])));
endmodule

// File: tb/pass_window_locator_tb.sv
module pass_window_locator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAST = 252;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_fall = 1'b0;
  logic [8:0]   req_start = '0;
  logic [255:0] bitmap = '0;
  logic         done;
  logic         found;
  logic [8:0]   found_idx;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pass_window_locator u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_fall(req_fall), .req_start(req_start), .bitmap(bitmap),
    .done(done), .found(found), .found_idx(found_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_find(input logic [255:0] m, input bit fall, input int s);
    int cs;
    if (fall && s < 0) return -1;
    if (s > LAST) return -1;
    cs = (s < 3) ? 3 : s;
    for (int i = cs; i <= LAST; i++) begin
      if (!fall) begin
        if (!m[i-1] && m[i] && m[i+1] && m[i+2] && m[i+3]) return i;
      end else begin
        if (!m[i] && m[i-1] && m[i-2] && m[i-3]) return i;
      end
    end
    return -1;
  endfunction

  function automatic int ref_lat(input bit fall, input int s, input int idx);
    int cs;
    if ((fall && s < 0) || s > LAST) return 0;
    cs = (s < 3) ? 3 : s;
    if (idx >= 0) return idx - cs + 1;
    return LAST - cs + 1;
  endfunction

  function automatic logic [255:0] mk_win(input int lo, input int hi);
    logic [255:0] m = '0;
    for (int i = 0; i < 256; i++) if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  task automatic run_search(input logic [255:0] m, input bit fall, input int s,
                            input bit disturb, input string req, output int res);
    int exp_idx;
    int exp_lat;
    int n;
    exp_idx = ref_find(m, fall, s);
    exp_lat = ref_lat(fall, s, exp_idx);
    @(negedge clk);
    check(req_ready, "R10 ready before request", int'(req_ready), 1);
    bitmap = m; req_fall = fall; req_start = s[8:0]; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 300) begin
      if (disturb && n == 1 && exp_lat >= 3) begin
        check(!req_ready, "R10 busy", int'(req_ready), 0);
        bitmap = ~m; req_valid = 1'b1; req_fall = !fall; req_start = 9'd3;
      end
      if (n == 2) req_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    check(n == exp_lat, {req, " R9 latency"}, n, exp_lat);
    check(found == (exp_idx >= 0), {req, " R8 found flag"}, int'(found), int'(exp_idx >= 0));
    check($signed(found_idx) == exp_idx, {req, " R4 index"}, int'($signed(found_idx)), exp_idx);
    @(negedge clk);
    check(!done, "R9 single pulse", int'(done), 0);
    res = exp_idx;
  endtask

  initial begin
    repeat (CLK_PERIOD * 19000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    int f;
    logic [255:0] gm;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready, "R1 ready", int'(req_ready), 1);
    check(!done, "R1 done", int'(done), 0);
    check(!found, "R1 found", int'(found), 0);
    check(found_idx == 9'h1FF, "R1 idx", int'(found_idx), 511);
    rst_n = 1'b1;

    // R2 R3 R5: clean windows near the low boundary, rising then falling
    for (int lo = 0; lo <= 12; lo++) begin
      for (int k = 0; k < 5; k++) begin
        int hi;
        hi = (k == 0) ? lo + 2 : (k == 1) ? lo + 3 : (k == 2) ? lo + 4 : (k == 3) ? 100 : 255;
        run_search(mk_win(lo, hi), 1'b0, -1, 1'b0, "R2 R5 rise", r);
        run_search(mk_win(lo, hi), 1'b1, r, 1'b0, "R3 R7 fall", f);
      end
    end

    // R6: windows touching the top of the map
    for (int lo = 245; lo <= 255; lo++) begin
      run_search(mk_win(lo, 255), 1'b0, 0, 1'b0, "R6 top rise", r);
      run_search(mk_win(lo, 255), 1'b1, r, 1'b0, "R6 top fall", f);
    end

    // Glitch map: lone pass, 3-long pass run, fail glitch inside window
    gm = mk_win(60, 120);
    gm[40] = 1'b1;
    gm[48] = 1'b1; gm[49] = 1'b1; gm[50] = 1'b1;
    gm[90] = 1'b0;
    gm[200] = 1'b1; gm[201] = 1'b1; gm[202] = 1'b1; gm[203] = 1'b1;
    for (int s = 0; s <= 8; s++) run_search(gm, 1'b0, s, 1'b0, "R5 start clamp", r);
    for (int s = 58; s <= 62; s++) run_search(gm, 1'b0, s, 1'b1, "R4 first match", r);
    run_search(gm, 1'b1, 60, 1'b1, "R3 fall glitch", f);
    run_search(gm, 1'b1, 91, 1'b1, "R3 fall after glitch", f);
    run_search(gm, 1'b0, 253, 1'b0, "R6 start 253", r);
    run_search(gm, 1'b1, 255, 1'b0, "R6 start 255", r);
    run_search(gm, 1'b1, -5, 1'b0, "R7 negative fall", r);
    run_search(mk_win(0, 2) | mk_win(4, 9), 1'b1, 0, 1'b0, "R3 fall at 3", r);

    // Random run maps with busy-time disturbance
    for (int t = 0; t < 60; t++) begin
      logic [255:0] m;
      bit cur;
      cur = 1'($urandom % 2);
      for (int i = 0; i < 256; i++) begin
        if ($urandom % 6 == 0) cur = !cur;
        m[i] = cur;
      end
      run_search(m, 1'b0, -1, 1'b1, "R2 R10 random rise", r);
      run_search(m, 1'b1, r, 1'b1, "R3 R10 random fall", f);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule